// File: doc/BRIEF.md
# Single-Precision Compare, Sign and Branch-Condition Unit

This unit sits beside a floating-point register file and takes care of the operations that look only at the bit pattern of a single-precision value. No arithmetic rounding is involved. It evaluates the relational compares that update the condition flag: equal, less-than, less-or-equal, and the always-false compare. It picks the smaller or larger of two operands, and it forces or flips the sign bit for absolute value and negation. It also decides whether a branch on the condition flag is taken. For the "likely" branch forms that are not taken, it tells the fetch logic to annul the delay-slot instruction.

Each operation is presented on one cycle with `inValid`, a 4-bit operation code, two operands and the current condition flag. Every result appears on the registered outputs on the following cycle. These outputs are the value to write back, the new condition flag, a two-bit cause-clear mask for the overflow and underflow cause bits, and the branch decision. A build-time mask, `CMP_MASK`, can drop low mantissa bits from both operands before a compare, so that values differing only by rounding noise compare as equal. NaN handling is not modelled: every pattern is ordered by sign and magnitude.

Operation codes: 0 compare-equal, 1 compare-less, 2 compare-less-or-equal, 3 compare-false, 4 minimum, 5 maximum, 6 absolute, 7 negate, 8 branch-if-clear, 9 branch-if-set, 10 likely branch-if-clear, 11 likely branch-if-set. Codes 12 to 15 are no-operations.

Top module: `fp_cond_unit`

## Requirements
- R1: After reset, every output is 0. `outValid` equals `inValid` from the previous cycle, and all other outputs describe the operation presented on that previous cycle.
- R2: Codes 0, 1 and 2 set `condWrite`=1 and drive `condOut`=1 exactly when A==B, A<B or A<=B respectively. Code 3 sets `condWrite`=1 and always drives `condOut`=0.
- R3: Compares order patterns by sign and magnitude. The sign is bit 31 and the magnitude is bits 30:0. A larger magnitude is larger when the sign is clear and smaller when the sign is set. +0 and -0 compare as equal.
- R4: For codes 0 to 2, both operands are ANDed with the parameter `CMP_MASK` before the compare. With the default all-ones mask, the compare is exact. With mask 32'hFFFF_FFFC, operands that differ only in bits 1:0 compare as equal.
- R5: Code 6 returns A with bit 31 cleared. Code 7 returns A with bit 31 inverted. All other bits pass unchanged.
- R6: Code 4 returns B if B<A and otherwise A. Code 5 returns B if A<B and otherwise A. Both use the R3 ordering without the mask, return an operand bit pattern unchanged, and return A when the operands are equal.
- R7: Codes 4 to 7 drive `clearCause`=2'b11 (bit 0 for overflow, bit 1 for underflow) and `resultWrite`=1. Every other code drives `clearCause`=0 and `resultWrite`=0, with `result`=0.
- R8: Codes 8 and 10 drive `branchTaken`=1 when `condIn` is 0. Codes 9 and 11 drive `branchTaken`=1 when `condIn` is 1. Other codes never take a branch.
- R9: Codes 10 and 11 drive `annulSlot`=1 when their branch is not taken. Codes 8 and 9, and all other codes, never annul. `annulSlot` and `branchTaken` are never both 1.
- R10: For every code other than 0 to 3, `condWrite` is 0 and `condOut` repeats the `condIn` of the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| inValid | input | 1 | An operation is presented this cycle |
| opSel | input | 4 | Operation code |
| opA | input | 32 | First operand |
| opB | input | 32 | Second operand |
| condIn | input | 1 | Current condition flag |
| outValid | output | 1 | Outputs describe an operation |
| result | output | 32 | Value for write-back |
| resultWrite | output | 1 | `result` should be written |
| condOut | output | 1 | New condition flag |
| condWrite | output | 1 | Condition flag was computed by a compare |
| clearCause | output | 2 | Cause bits to clear: bit 0 overflow, bit 1 underflow |
| branchTaken | output | 1 | Branch on condition is taken |
| annulSlot | output | 1 | Skip the delay-slot instruction |

## Verification
Every output is due exactly one clock edge after its operation is presented. The bench drives each operation on a falling edge and samples all outputs on the next falling edge, half a period after the capturing rising edge. Directed cases cover signed zeros, equal operands, single-bit magnitude steps and all branch forms under both flag values. Random cases draw operand pairs that are often equal, sign-flipped or one step apart. A second instance with a masked compare receives the same stimulus, and its condition flag is checked against the masked model.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
  typedef enum logic [3:0] {
    OP_CEQ = 4'd0, OP_CLT = 4'd1, OP_CLE = 4'd2, OP_CF  = 4'd3,
    OP_MIN = 4'd4, OP_MAX = 4'd5, OP_ABS = 4'd6, OP_NEG = 4'd7,
    OP_BF  = 4'd8, OP_BT  = 4'd9, OP_BFL = 4'd10, OP_BTL = 4'd11
  } fpcOp_e;

  typedef enum logic [1:0] {REL_EQ, REL_LT, REL_LE, REL_NONE} relSel_e;

  localparam int CAUSE_W = 2;

  typedef struct packed {
    logic    valid;
    logic    cmpEn;
    relSel_e rel;
    logic    selMin;
    logic    selMax;
    logic    doAbs;
    logic    doNeg;
    logic    brEn;
    logic    brOnTrue;
    logic    brLikely;
  } fpcStrobe_t;
endpackage

// File: rtl/fpc_ctrl.sv
module fpc_ctrl
  import fpc_pkg::*;
(
  input  logic       inValid,
  input  logic [3:0] opSel,
  output fpcStrobe_t strobe
);
  always_comb begin
    strobe       = '0;
    strobe.rel   = REL_NONE;
    strobe.valid = inValid;
    if (inValid) begin
      case (opSel)
        OP_CEQ: begin strobe.cmpEn = 1'b1; strobe.rel = REL_EQ; end
        OP_CLT: begin strobe.cmpEn = 1'b1; strobe.rel = REL_LT; end
        OP_CLE: begin strobe.cmpEn = 1'b1; strobe.rel = REL_LE; end
        OP_CF:  begin strobe.cmpEn = 1'b1; strobe.rel = REL_NONE; end
        OP_MIN: strobe.selMin = 1'b1;
        OP_MAX: strobe.selMax = 1'b1;
        OP_ABS: strobe.doAbs  = 1'b1;
        OP_NEG: strobe.doNeg  = 1'b1;
        OP_BF:  strobe.brEn   = 1'b1;
        OP_BT:  begin strobe.brEn = 1'b1; strobe.brOnTrue = 1'b1; end
        OP_BFL: begin strobe.brEn = 1'b1; strobe.brLikely = 1'b1; end
        OP_BTL: begin strobe.brEn = 1'b1; strobe.brOnTrue = 1'b1; strobe.brLikely = 1'b1; end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/fpc_dp.sv
module fpc_dp
  import fpc_pkg::*;
#(
  parameter int                DATA_W   = 32,
  parameter logic [DATA_W-1:0] CMP_MASK = '1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  fpcStrobe_t         strobe,
  input  logic [DATA_W-1:0]  opA,
  input  logic [DATA_W-1:0]  opB,
  input  logic               condIn,
  output logic               outValid,
  output logic [DATA_W-1:0]  result,
  output logic               resultWrite,
  output logic               condOut,
  output logic               condWrite,
  output logic [CAUSE_W-1:0] clearCause,
  output logic               branchTaken,
  output logic               annulSlot
);
  localparam int SIGN_B = DATA_W - 1;
  localparam logic [DATA_W-1:0] SIGN_BIT = {1'b1, {(DATA_W-1){1'b0}}};

  function automatic logic smLess(input logic [DATA_W-1:0] x, input logic [DATA_W-1:0] y);
    logic bothZero;
    bothZero = (x[SIGN_B-1:0] == '0) && (y[SIGN_B-1:0] == '0);
    if (bothZero)               smLess = 1'b0;
    else if (x[SIGN_B] != y[SIGN_B]) smLess = x[SIGN_B];
    else if (!x[SIGN_B])        smLess = x[SIGN_B-1:0] < y[SIGN_B-1:0];
    else                        smLess = x[SIGN_B-1:0] > y[SIGN_B-1:0];
  endfunction

  function automatic logic smEqual(input logic [DATA_W-1:0] x, input logic [DATA_W-1:0] y);
    smEqual = (x == y) || ((x[SIGN_B-1:0] == '0) && (y[SIGN_B-1:0] == '0));
  endfunction

  logic [DATA_W-1:0] cmpA, cmpB;
  generate
    if (CMP_MASK == {DATA_W{1'b1}}) begin : g_exactCmp
      assign cmpA = opA;
      assign cmpB = opB;
    end else begin : g_maskedCmp
      assign cmpA = opA & CMP_MASK;
      assign cmpB = opB & CMP_MASK;
    end
  endgenerate

  logic relEq, relLt, relHit;
  logic aBelowB, bBelowA;
  assign relEq   = smEqual(cmpA, cmpB);
  assign relLt   = smLess(cmpA, cmpB);
  assign aBelowB = smLess(opA, opB);
  assign bBelowA = smLess(opB, opA);

  always_comb begin
    case (strobe.rel)
      REL_EQ:  relHit = relEq;
      REL_LT:  relHit = relLt;
      REL_LE:  relHit = relLt | relEq;
      default: relHit = 1'b0;
    endcase
  end

  logic [DATA_W-1:0] resNext;
  logic              resWrNext, takeNext;
  always_comb begin
    resNext = '0;
    if (strobe.selMin)     resNext = bBelowA ? opB : opA;
    else if (strobe.selMax) resNext = aBelowB ? opB : opA;
    else if (strobe.doAbs)  resNext = opA & ~SIGN_BIT;
    else if (strobe.doNeg)  resNext = opA ^ SIGN_BIT;
    resWrNext = strobe.selMin | strobe.selMax | strobe.doAbs | strobe.doNeg;
    takeNext  = strobe.brEn & (condIn == strobe.brOnTrue);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outValid    <= 1'b0;
      result      <= '0;
      resultWrite <= 1'b0;
      condOut     <= 1'b0;
      condWrite   <= 1'b0;
      clearCause  <= '0;
      branchTaken <= 1'b0;
      annulSlot   <= 1'b0;
    end else begin
      outValid    <= strobe.valid;
      result      <= resNext;
      resultWrite <= resWrNext;
      condOut     <= strobe.cmpEn ? relHit : condIn;
      condWrite   <= strobe.cmpEn;
      clearCause  <= {CAUSE_W{resWrNext}};
      branchTaken <= takeNext;
      annulSlot   <= strobe.brEn & strobe.brLikely & ~takeNext;
    end
  end
endmodule

// File: rtl/fp_cond_unit.sv
module fp_cond_unit
  import fpc_pkg::*;
#(
  parameter int                DATA_W   = 32,
  parameter logic [DATA_W-1:0] CMP_MASK = '1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               inValid,
  input  logic [3:0]         opSel,
  input  logic [DATA_W-1:0]  opA,
  input  logic [DATA_W-1:0]  opB,
  input  logic               condIn,
  output logic               outValid,
  output logic [DATA_W-1:0]  result,
  output logic               resultWrite,
  output logic               condOut,
  output logic               condWrite,
  output logic [1:0]         clearCause,
  output logic               branchTaken,
  output logic               annulSlot
);
  fpcStrobe_t strobe;

  fpc_ctrl ctrl_i (
    .inValid (inValid),
    .opSel   (opSel),
    .strobe  (strobe)
  );

  fpc_dp #(.DATA_W(DATA_W), .CMP_MASK(CMP_MASK)) dp_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobe      (strobe),
    .opA         (opA),
    .opB         (opB),
    .condIn      (condIn),
    .outValid    (outValid),
    .result      (result),
    .resultWrite (resultWrite),
    .condOut     (condOut),
    .condWrite   (condWrite),
    .clearCause  (clearCause),
    .branchTaken (branchTaken),
    .annulSlot   (annulSlot)
  );
endmodule

// File: rtl/fpc_checker.sv
module fpc_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              inValid,
  input logic [3:0]        opSel,
  input logic [DATA_W-1:0] opA,
  input logic [DATA_W-1:0] opB,
  input logic              condIn,
  input logic              outValid,
  input logic [DATA_W-1:0] result,
  input logic              resultWrite,
  input logic              condOut,
  input logic              condWrite,
  input logic [1:0]        clearCause,
  input logic              branchTaken,
  input logic              annulSlot
);
  AST_VALID_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    inValid |=> outValid); // R1
  AST_CMPF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && opSel == 4'd3) |=> (condWrite && !condOut)); // R2
  AST_ABS_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && opSel == 4'd6) |=> (!result[DATA_W-1] && result[DATA_W-2:0] == $past(opA[DATA_W-2:0]))); // R5
  AST_NEG_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && opSel == 4'd7) |=> (result[DATA_W-1] != $past(opA[DATA_W-1]) && result[DATA_W-2:0] == $past(opA[DATA_W-2:0]))); // R5
  AST_MINMAX_OPERAND: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && (opSel == 4'd4 || opSel == 4'd5)) |=> (result == $past(opA) || result == $past(opB))); // R6
  AST_CAUSE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && opSel >= 4'd4 && opSel <= 4'd7) |=> (clearCause == 2'b11)); // R7
  AST_BRANCH_FALSE: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && opSel == 4'd8) |=> (branchTaken == !$past(condIn))); // R8
  AST_ANNUL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    annulSlot |-> !branchTaken); // R9
  AST_COND_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && opSel >= 4'd4) |=> (!condWrite && condOut == $past(condIn))); // R10
endmodule

bind fp_cond_unit fpc_checker #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .inValid(inValid), .opSel(opSel), .opA(opA),
  .opB(opB), .condIn(condIn), .outValid(outValid), .result(result),
  .resultWrite(resultWrite), .condOut(condOut), .condWrite(condWrite),
  .clearCause(clearCause), .branchTaken(branchTaken), .annulSlot(annulSlot)
);

// File: tb/fp_cond_unit_tb_top.sv
module fp_cond_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] MASK2 = 32'hFFFF_FFFC;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic inValid = 1'b0;
  logic [3:0] opSel = 4'd0;
  logic [31:0] opA = '0, opB = '0;
  logic condIn = 1'b0;

  logic outValid, resultWrite, condOut, condWrite, branchTaken, annulSlot;
  logic [31:0] result;
  logic [1:0] clearCause;
  logic mValid, mResWr, mCond, mCondWr, mTaken, mAnnul;
  logic [31:0] mResult;
  logic [1:0] mCause;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fp_cond_unit dut_i (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .opSel(opSel), .opA(opA), .opB(opB),
    .condIn(condIn), .outValid(outValid), .result(result), .resultWrite(resultWrite),
    .condOut(condOut), .condWrite(condWrite), .clearCause(clearCause),
    .branchTaken(branchTaken), .annulSlot(annulSlot));

  fp_cond_unit #(.CMP_MASK(MASK2)) dut_m (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .opSel(opSel), .opA(opA), .opB(opB),
    .condIn(condIn), .outValid(mValid), .result(mResult), .resultWrite(mResWr),
    .condOut(mCond), .condWrite(mCondWr), .clearCause(mCause),
    .branchTaken(mTaken), .annulSlot(mAnnul));

  // Order key: signed integer from sign/magnitude, both zeros map to 0.
  function automatic longint keyOf(input logic [31:0] v);
    longint m = longint'(v[30:0]);
    return v[31] ? -m : m;
  endfunction

  function automatic logic modelCond(input logic [3:0] op, input logic [31:0] a,
                                     input logic [31:0] b, input logic [31:0] mask);
    longint ka = keyOf(a & mask);
    longint kb = keyOf(b & mask);
    case (op)
      4'd0: return ka == kb;
      4'd1: return ka < kb;
      4'd2: return ka <= kb;
      default: return 1'b0;
    endcase
  endfunction

  // Packed expectation: valid, result, resWr, cond, condWr, cause, taken, annul
  function automatic logic [39:0] model(input logic [3:0] op, input logic [31:0] a,
                                        input logic [31:0] b, input logic c);
    logic [31:0] r = '0;
    logic rw = 1'b0, co = c, cw = 1'b0, tk = 1'b0, an = 1'b0;
    if (op <= 4'd3) begin cw = 1'b1; co = modelCond(op, a, b, 32'hFFFF_FFFF); end
    if (op == 4'd4) begin rw = 1'b1; r = (keyOf(b) < keyOf(a)) ? b : a; end
    if (op == 4'd5) begin rw = 1'b1; r = (keyOf(a) < keyOf(b)) ? b : a; end
    if (op == 4'd6) begin rw = 1'b1; r = {1'b0, a[30:0]}; end
    if (op == 4'd7) begin rw = 1'b1; r = {~a[31], a[30:0]}; end
    if (op >= 4'd8 && op <= 4'd11) begin
      tk = (op == 4'd9 || op == 4'd11) ? c : ~c;
      an = (op >= 4'd10) && !tk;
    end
    return {1'b1, r, rw, co, cw, {rw, rw}, tk, an};
  endfunction

  function automatic string tagOf(input logic [3:0] op);
    if (op <= 4'd3) return "R2/R3";
    if (op <= 4'd5) return "R6";
    if (op <= 4'd7) return "R5/R7";
    if (op >= 4'd10 && op <= 4'd11) return "R9";
    if (op >= 4'd8 && op <= 4'd9) return "R8";
    return "R10";
  endfunction

  task automatic check(input string tag, input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic runOp(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b, input logic c);
    logic [39:0] exp;
    @(negedge clk);
    inValid = 1'b1; opSel = op; opA = a; opB = b; condIn = c;
    exp = model(op, a, b, c);
    @(negedge clk);
    check(tagOf(op), {outValid, result, resultWrite, condOut, condWrite, clearCause, branchTaken, annulSlot}, exp);
    if (op <= 4'd7) check("R7", {38'd0, clearCause}, {38'd0, exp[3:2]});
    if (op <= 4'd2) check("R4", {39'd0, mCond}, {39'd0, modelCond(op, a, b, MASK2)});
  endtask

  function automatic logic [31:0] pickB(input logic [31:0] a);
    case ($urandom % 7)
      0: return a;
      1: return a ^ 32'h8000_0000;
      2: return a + 32'd1;
      3: return a - 32'd1;
      4: return {a[31:2], 2'($urandom)};
      5: return {1'($urandom), 31'd0};
      default: return $urandom;
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", {outValid, result, resultWrite, condOut, condWrite, clearCause, branchTaken, annulSlot}, 40'd0);
    rst_n = 1'b1;
    // R3: signed zeros and sign ordering
    runOp(4'd0, 32'h0000_0000, 32'h8000_0000, 1'b0);
    runOp(4'd1, 32'h8000_0000, 32'h0000_0000, 1'b1);
    runOp(4'd1, 32'hBF80_0000, 32'h3F80_0000, 1'b0);
    runOp(4'd1, 32'hC000_0000, 32'hBF80_0000, 1'b0);
    runOp(4'd2, 32'h3F80_0001, 32'h3F80_0000, 1'b1);
    runOp(4'd3, 32'h1234_5678, 32'h1234_5678, 1'b1);
    // R4: differs only in low two bits
    runOp(4'd0, 32'h4000_0001, 32'h4000_0002, 1'b0);
    runOp(4'd1, 32'h4000_0000, 32'h4000_0003, 1'b0);
    // R6: equality returns A
    runOp(4'd4, 32'h0000_0000, 32'h8000_0000, 1'b0);
    runOp(4'd5, 32'h8000_0000, 32'h0000_0000, 1'b0);
    runOp(4'd4, 32'hC000_0000, 32'h3F80_0000, 1'b0);
    runOp(4'd5, 32'hC000_0000, 32'h3F80_0000, 1'b0);
    // R5
    runOp(4'd6, 32'hFFFF_FFFF, 32'd0, 1'b1);
    runOp(4'd7, 32'h7F80_0000, 32'd0, 1'b0);
    // R8/R9 all branch forms with both flag values
    for (int op = 8; op <= 11; op++) begin
      runOp(4'(op), 32'd0, 32'd0, 1'b0);
      runOp(4'(op), 32'd0, 32'd0, 1'b1);
    end
    // R10: no-op codes pass the flag
    runOp(4'd12, 32'h1, 32'h2, 1'b1);
    runOp(4'd15, 32'h1, 32'h2, 1'b0);
    // Random mix
    for (int i = 0; i < 600; i++) begin
      logic [31:0] a;
      a = $urandom;
      if ($urandom % 5 == 0) a = {a[31], 31'd0};
      runOp(4'($urandom % 16), a, pickB(a), 1'($urandom));
    end
    // R1: idle cycle clears outValid
    @(negedge clk);
    inValid = 1'b0;
    @(negedge clk);
    check("R1", {39'd0, outValid}, 40'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule